// File: doc/BRIEF.md
# SPI Master Core with Register Interface

This block is a single-word SPI master sitting behind a small 32-bit register file. Software picks one of eight chip-select lines and sets its active bit, chooses the clock polarity, clock phase, word width (8 or 16 bits) and the bit order for each direction, and then writes a word to the transmit register. The core shifts that word out on MOSI while it assembles the reply from MISO. When the word is finished, it sets a completion flag and places the received word in the receive register.

The SCK rate does not come from inside the core. A prescaler outside the block sends a one-cycle enable pulse, and each pulse advances SCK by one half-period. The MISO capture point can be moved one core clock later, which gives extra hold margin when SCK runs fast.

Top module: `spim_core`

## Requirements
- R1: After reset, every register reads zero except the timing register, which reads 0x40 (sample-point field = 1). Offsets are control 0x00, configuration 0x04, transmit 0x08 (reads zero), receive 0x0C, completion 0x10 and timing 0x18.
- R2: Control bits [4:2] select a chip-select line and control bit 0 activates it. When active, only `spi_cs_n[sel]` is low. When inactive, all chip-select lines are high. Both fields read back from the control register.
- R3: Configuration bit 11 sets the SCK idle level, and SCK sits at that level before and after every word. Configuration bit 12 chooses the capture edge: clear captures on the leading edge of each bit, set captures on the trailing edge. MOSI changes on the other edge.
- R4: Configuration bit 5 selects 16-bit words when set and 8-bit words when clear. A word produces exactly twice as many SCK transitions as it has bits.
- R5: Configuration bit 13 clear sends the transmit word from its top bit (bit 15 or bit 7) downward. When set, the word is sent from bit 0 upward.
- R6: Configuration bit 14 clear places the first received bit at the top bit of the word. When set, the first received bit goes to bit 0.
- R7: Writing the transmit register while the core is idle starts a word. Control bit 8 reads 1 for as long as that word is in progress.
- R8: The completion register reads 1 once a word has finished. Any write to it clears it to 0.
- R9: The receive register holds the last received word, zero-extended to 32 bits. It does not change until the next word finishes.
- R10: A write to the transmit register while a word is in progress has no effect: the bits on MOSI still come from the first word.
- R11: A timing field [7:6] value of 2 captures MISO two core clocks after the capturing SCK edge is registered. Any other value captures one core clock after that edge.
- R12: SCK changes only in a cycle that follows a `sck_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_en | input | 1 | Half-period advance pulse from the external prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 8 | Active-low chip selects |

## Verification
The assertions assume that the configuration and timing registers hold steady while a word is in progress. The stimulus programs them only while control bit 8 reads 0. The sample-delay properties also assume that `sck_en` pulses are spaced far enough apart that MISO capture finishes before the next SCK edge. The bench therefore sends one pulse every fourth core clock. Its slave model changes MISO only on the shifting edge, except in the sample-point test, where MISO is pulsed high for exactly the second core clock after each capturing edge.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
// Package: register offsets, bit positions and the per-word configuration
// bundle shared by the SPI master core and its engine.
package spim_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_TXD    = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RXD    = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CAUSE  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_TIMING = 5'h18;

    localparam int CTL_ACT    = 0;
    localparam int CTL_SEL_LO = 2;
    localparam int CTL_BUSY   = 8;
    localparam int CFG_WIDE   = 5;
    localparam int CFG_CPOL   = 11;
    localparam int CFG_CPHA   = 12;
    localparam int CFG_TXLSB  = 13;
    localparam int CFG_RXLSB  = 14;
    localparam int TIM_LO     = 6;
    localparam int TIM_W      = 2;

    localparam logic [TIM_W-1:0] TIM_RESET = 2'd1;
    localparam logic [TIM_W-1:0] TIM_LATE  = 2'd2;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic wide;
        logic tx_lsb;
        logic rx_lsb;
        logic late;
    } xfer_cfg_t;
endpackage

// File: rtl/spim_csdec.sv
`timescale 1ns/1ps
// Chip-select decoder: turns an encoded line number and an active bit into
// active-low select lines. Assumes sel is a valid line number.
module spim_csdec #(
    parameter int NUM_CS = 8,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic [CS_W-1:0]   sel,
    output logic [NUM_CS-1:0] cs_n
);
    // One decoder slice per select line.
    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_line
        assign cs_n[gi] = !(act && (sel == CS_W'(gi)));
    end

    // R2: never more than one line low
    a_r2_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R2: inactive releases every line
    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (&cs_n));
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
// Shift engine: serialises one word of 8 or WIDE_BITS bits per start pulse,
// paced by sck_en half-period pulses, with optional one-clock-late MISO
// capture. Assumes cfg is held steady while busy.
module spim_shift
    import spim_pkg::*;
#(
    parameter int WIDE_BITS   = 16,
    parameter int NARROW_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck_en,
    input  logic                 start,
    input  logic [WIDE_BITS-1:0] tx_word,
    input  xfer_cfg_t            cfg,
    input  logic                 miso,
    output logic                 busy,
    output logic                 sck,
    output logic                 mosi,
    output logic                 done,
    output logic [WIDE_BITS-1:0] rx_word
);
    localparam int CNT_W = $clog2(2 * WIDE_BITS + 1);
    localparam int IDX_W = $clog2(WIDE_BITS);

    logic                 busy_q, sck_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [WIDE_BITS-1:0] txw_q, rxw_q;
    logic                 a_v, b_v;
    logic [IDX_W-1:0]     a_idx, b_idx;

    logic [CNT_W-1:0] nbits, last_cnt, drv_raw, drv_idx, tx_pos, rx_pos;
    logic             cap_v;
    logic [IDX_W-1:0] cap_idx;

    // Word length, terminal edge count and the bit currently driven.
    always_comb begin
        nbits    = cfg.wide ? CNT_W'(WIDE_BITS) : CNT_W'(NARROW_BITS);
        last_cnt = nbits << 1;
        drv_raw  = (cfg.cpha && cnt_q != '0) ? ((cnt_q - 1'b1) >> 1) : (cnt_q >> 1);
        drv_idx  = (drv_raw >= nbits) ? (nbits - 1'b1) : drv_raw;
        tx_pos   = cfg.tx_lsb ? drv_idx : (nbits - 1'b1 - drv_idx);
    end

    // Select the capture stage by sample-point setting and place the bit.
    always_comb begin
        cap_v   = cfg.late ? b_v : a_v;
        cap_idx = cfg.late ? b_idx : a_idx;
        rx_pos  = cfg.rx_lsb ? CNT_W'(cap_idx) : (nbits - 1'b1 - CNT_W'(cap_idx));
    end

    assign done    = busy_q && (cnt_q == last_cnt) && !a_v && !b_v;
    assign busy    = busy_q;
    assign sck     = sck_q;
    assign mosi    = busy_q & txw_q[tx_pos[IDX_W-1:0]];
    assign rx_word = rxw_q;

    // Sequencer: start, SCK toggling, capture pipeline and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            cnt_q  <= '0;
            txw_q  <= '0;
            rxw_q  <= '0;
            a_v    <= 1'b0;
            b_v    <= 1'b0;
            a_idx  <= '0;
            b_idx  <= '0;
        end else begin
            a_v   <= 1'b0;
            b_v   <= cfg.late && a_v;
            b_idx <= a_idx;
            if (cap_v) begin
                rxw_q[rx_pos[IDX_W-1:0]] <= miso;
            end
            if (!busy_q) begin
                sck_q <= cfg.cpol;
                if (start) begin
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                    txw_q  <= tx_word;
                    rxw_q  <= '0;
                end
            end else if (done) begin
                busy_q <= 1'b0;
            end else if (sck_en && cnt_q != last_cnt) begin
                sck_q <= ~sck_q;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q[0] == cfg.cpha) begin
                    a_v   <= 1'b1;
                    a_idx <= IDX_W'(cnt_q >> 1);
                end
            end
        end
    end

    // R4: edge count never passes the word's terminal count
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= last_cnt));
    // R3: SCK is back at idle level when the word ends
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (sck_q == cfg.cpol));
    // R10: a start while busy leaves the held word untouched
    a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> $stable(txw_q));
    // R12: without a pulse, SCK holds during a word
    a_r12_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !sck_en) |=> $stable(sck_q));
endmodule

// File: rtl/spim_core.sv
`timescale 1ns/1ps
// SPI master core: register file (control, configuration, transmit,
// receive, completion, timing) around the shift engine and chip-select
// decoder. Assumes configuration and timing are written only while idle.
module spim_core
    import spim_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int WIDE_BITS   = 16,
    parameter int NARROW_BITS = 8,
    parameter int NUM_CS      = 8,
    localparam int CS_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    logic                 act_q;
    logic [CS_W-1:0]      sel_q;
    logic                 cpol_q, cpha_q, wide_q, txlsb_q, rxlsb_q;
    logic [TIM_W-1:0]     tim_q;
    logic                 cause_q;
    logic [WIDE_BITS-1:0] din_q;

    xfer_cfg_t            cfg_s;
    logic                 eng_busy, eng_done, start_s;
    logic [WIDE_BITS-1:0] eng_rx;

    // Pack the per-word settings for the engine.
    always_comb begin
        cfg_s.cpol   = cpol_q;
        cfg_s.cpha   = cpha_q;
        cfg_s.wide   = wide_q;
        cfg_s.tx_lsb = txlsb_q;
        cfg_s.rx_lsb = rxlsb_q;
        cfg_s.late   = (tim_q == TIM_LATE);
    end

    assign start_s = reg_wr && (reg_addr == OFS_TXD);

    // Register writes, completion flag and received-word latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            sel_q   <= '0;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            wide_q  <= 1'b0;
            txlsb_q <= 1'b0;
            rxlsb_q <= 1'b0;
            tim_q   <= TIM_RESET;
            cause_q <= 1'b0;
            din_q   <= '0;
        end else begin
            if (reg_wr && reg_addr == OFS_CTRL) begin
                act_q <= reg_wdata[CTL_ACT];
                sel_q <= reg_wdata[CTL_SEL_LO +: CS_W];
            end
            if (reg_wr && reg_addr == OFS_CFG) begin
                cpol_q  <= reg_wdata[CFG_CPOL];
                cpha_q  <= reg_wdata[CFG_CPHA];
                wide_q  <= reg_wdata[CFG_WIDE];
                txlsb_q <= reg_wdata[CFG_TXLSB];
                rxlsb_q <= reg_wdata[CFG_RXLSB];
            end
            if (reg_wr && reg_addr == OFS_TIMING) begin
                tim_q <= reg_wdata[TIM_LO +: TIM_W];
            end
            if (eng_done) begin
                cause_q <= 1'b1;
            end else if (reg_wr && reg_addr == OFS_CAUSE) begin
                cause_q <= 1'b0;
            end
            if (eng_done) begin
                din_q <= eng_rx;
            end
        end
    end

    // Read multiplexer; unlisted offsets and bits read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CTL_ACT]              = act_q;
                reg_rdata[CTL_SEL_LO +: CS_W]   = sel_q;
                reg_rdata[CTL_BUSY]             = eng_busy;
            end
            OFS_CFG: begin
                reg_rdata[CFG_CPOL]  = cpol_q;
                reg_rdata[CFG_CPHA]  = cpha_q;
                reg_rdata[CFG_WIDE]  = wide_q;
                reg_rdata[CFG_TXLSB] = txlsb_q;
                reg_rdata[CFG_RXLSB] = rxlsb_q;
            end
            OFS_RXD:    reg_rdata[WIDE_BITS-1:0]  = din_q;
            OFS_CAUSE:  reg_rdata[0]              = cause_q;
            OFS_TIMING: reg_rdata[TIM_LO +: TIM_W] = tim_q;
            default:    reg_rdata = '0;
        endcase
    end

    spim_shift #(
        .WIDE_BITS  (WIDE_BITS),
        .NARROW_BITS(NARROW_BITS)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_en (sck_en),
        .start  (start_s),
        .tx_word(reg_wdata[WIDE_BITS-1:0]),
        .cfg    (cfg_s),
        .miso   (spi_miso),
        .busy   (eng_busy),
        .sck    (spi_sck),
        .mosi   (spi_mosi),
        .done   (eng_done),
        .rx_word(eng_rx)
    );

    spim_csdec #(
        .NUM_CS(NUM_CS)
    ) u_csdec (
        .clk  (clk),
        .rst_n(rst_n),
        .act  (act_q),
        .sel  (sel_q),
        .cs_n (spi_cs_n)
    );

    // R8: completion always raises the flag
    a_r8_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> cause_q);
    // R9: received word holds between completions
    a_r9_din_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_done |=> $stable(din_q));
    // R7: an idle transmit write starts a word
    a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_busy && start_s) |=> eng_busy);
endmodule

// File: tb/spim_core_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every mode/width/order combination against a slave model,
// plus chip-select, sample-point, ignore-while-busy and reset checks.
module spim_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [7:0]  spi_cs_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spim_core u_spim_core (
        .clk(clk), .rst_n(rst_n), .sck_en(sck_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // monitor / slave state
    bit          m_on = 1'b0;
    int          m_n = 8;
    bit          m_cpha = 1'b0;
    bit          m_late = 1'b0;
    logic [15:0] m_sl = '0;
    int          m_edges = 0;
    logic [15:0] m_wire = '0;
    int          m_ph = 0;
    int          stray = 0;
    int          en_div = 0;
    logic        prev_sck = 1'b0;
    logic [31:0] last_rx = '0;

    function automatic logic [15:0] rev_n(input logic [15:0] v, input int n);
        logic [15:0] r = '0;
        for (int b = 0; b < n; b++) r[b] = v[n-1-b];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Enable generator, SCK edge monitor and slave model.
    always @(negedge clk) begin
        bit chg, samp;
        int k;
        chg = (spi_sck !== prev_sck);
        if (chg && m_on && !sck_en) stray++;
        if (chg && m_on) begin
            m_edges++;
            samp = ((m_edges % 2) == 1) == (m_cpha == 1'b0);
            if (samp) m_wire = {m_wire[14:0], spi_mosi};
            if (m_late) begin
                if (samp) begin spi_miso = 1'b0; m_ph = 1; end
            end else begin
                k = m_cpha ? (m_edges - 1) / 2 : m_edges / 2;
                if (k < m_n) spi_miso = m_sl[m_n-1-k];
            end
        end else if (m_late && m_ph == 1) begin
            spi_miso = 1'b1; m_ph = 2;
        end else if (m_late && m_ph == 2) begin
            spi_miso = 1'b0; m_ph = 0;
        end
        prev_sck = spi_sck;
        sck_en = (en_div == 3);
        en_div = (en_div + 1) % 4;
    end

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 4000; i++) begin
            reg_read(5'h00, d);
            if (!d[8]) return;
        end
        check(1'b0, "R7 busy never cleared", d, 32'h0);
    endtask

    // One word: program, start, optionally poke a second word, verify.
    task automatic do_xfer(input bit cpol, input bit cpha, input bit wide,
                           input bit txl, input bit rxl, input logic [15:0] tx,
                           input logic [15:0] sl, input bit late, input bit poke,
                           input logic [31:0] exp_rx_override, input bit use_override);
        logic [31:0] d, exp_rx;
        int n;
        n = wide ? 16 : 8;
        reg_write(5'h04, (32'(wide) << 5) | (32'(cpol) << 11) | (32'(cpha) << 12) |
                         (32'(txl) << 13) | (32'(rxl) << 14));
        @(negedge clk); @(negedge clk);
        check(spi_sck == cpol, "R3 idle level before word", 32'(spi_sck), 32'(cpol));
        m_n = n; m_cpha = cpha; m_late = late; m_sl = sl; m_edges = 0;
        m_wire = '0; m_ph = 0;
        spi_miso = late ? 1'b0 : sl[n-1];
        m_on = 1'b1;
        reg_write(5'h08, {16'h0, tx});
        reg_read(5'h00, d);
        check(d[8] == 1'b1, "R7 busy during word", d, 32'h100);
        if (poke) reg_write(5'h08, {16'h0, ~tx});
        reg_read(5'h0C, d);
        check(d == last_rx, "R9 receive stable during word", d, last_rx);
        reg_read(5'h10, d);
        check(d == 32'h0, "R8 flag clear during word", d, 32'h0);
        wait_idle();
        m_on = 1'b0;
        check(m_edges == 2 * n, "R4 SCK transitions per word", m_edges, 2 * n);
        check(spi_sck == cpol, "R3 idle level after word", 32'(spi_sck), 32'(cpol));
        d = 32'(m_wire & ((n == 16) ? 16'hFFFF : 16'h00FF));
        if (poke)
            check(d == 32'(txl ? rev_n(tx, n) : (tx & ((n == 16) ? 16'hFFFF : 16'h00FF))),
                  "R10 busy write ignored", d,
                  32'(txl ? rev_n(tx, n) : (tx & ((n == 16) ? 16'hFFFF : 16'h00FF))));
        else
            check(d == 32'(txl ? rev_n(tx, n) : (tx & ((n == 16) ? 16'hFFFF : 16'h00FF))),
                  txl ? "R5 LSB-first transmit" : "R5 MSB-first transmit", d,
                  32'(txl ? rev_n(tx, n) : (tx & ((n == 16) ? 16'hFFFF : 16'h00FF))));
        exp_rx = use_override ? exp_rx_override :
                 32'(rxl ? rev_n(sl, n) : (sl & ((n == 16) ? 16'hFFFF : 16'h00FF)));
        reg_read(5'h0C, d);
        check(d == exp_rx, use_override ? "R11 sample point" : "R6 R9 receive word", d, exp_rx);
        last_rx = exp_rx;
        reg_read(5'h10, d);
        check(d == 32'h1, "R8 flag set on completion", d, 32'h1);
        reg_write(5'h10, 32'h0);
        reg_read(5'h10, d);
        check(d == 32'h0, "R8 flag cleared by write", d, 32'h0);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        reg_read(5'h00, d); check(d == 32'h0,  "R1 control reset", d, 32'h0);
        reg_read(5'h04, d); check(d == 32'h0,  "R1 config reset", d, 32'h0);
        reg_read(5'h08, d); check(d == 32'h0,  "R1 transmit reads zero", d, 32'h0);
        reg_read(5'h0C, d); check(d == 32'h0,  "R1 receive reset", d, 32'h0);
        reg_read(5'h10, d); check(d == 32'h0,  "R1 completion reset", d, 32'h0);
        reg_read(5'h18, d); check(d == 32'h40, "R1 timing reset", d, 32'h40);
        check(spi_cs_n == 8'hFF, "R1 R2 selects high at reset", 32'(spi_cs_n), 32'hFF);

        // R2 chip-select sweep
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 2; a++) begin
                reg_write(5'h00, (32'(s) << 2) | 32'(a));
                @(negedge clk);
                check(spi_cs_n == (a != 0 ? ~(8'h01 << s) : 8'hFF), "R2 select lines",
                      32'(spi_cs_n), 32'(a != 0 ? ~(8'h01 << s) : 8'hFF));
                reg_read(5'h00, d);
                check(d == ((32'(s) << 2) | 32'(a)), "R2 control readback", d,
                      (32'(s) << 2) | 32'(a));
            end
        end

        // Full mode / width / order sweep
        for (int i = 0; i < 32; i++) begin
            do_xfer(i[0], i[1], i[2], i[3], i[4],
                    16'hA5C3 ^ 16'(i * 16'h1357), 16'h3C96 ^ 16'(i * 16'h0F1E),
                    1'b0, 1'b0, 32'h0, 1'b0);
        end

        // R10 write while busy
        do_xfer(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h9C31, 16'h1234, 1'b0, 1'b1, 32'h0, 1'b0);
        do_xfer(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h00B6, 16'h004D, 1'b0, 1'b1, 32'h0, 1'b0);

        // R11 sample point: value 2 sees the late pulse, 1 and 0 do not
        reg_write(5'h18, 32'h80);
        reg_read(5'h18, d); check(d == 32'h80, "R11 timing readback", d, 32'h80);
        do_xfer(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h005A, 16'h0, 1'b1, 1'b0, 32'hFF, 1'b1);
        do_xfer(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h1E2D, 16'h0, 1'b1, 1'b0, 32'hFFFF, 1'b1);
        reg_write(5'h18, 32'h40);
        do_xfer(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h005A, 16'h0, 1'b1, 1'b0, 32'h0, 1'b1);
        reg_write(5'h18, 32'h00);
        do_xfer(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h7E81, 16'h0, 1'b1, 1'b0, 32'h0, 1'b1);

        // R12 pacing across all words
        check(stray == 0, "R12 SCK moved without enable", stray, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule